// File: doc/BRIEF.md
# Coalescing Receive Frame Queue

This block holds received CAN frames between the receive path and a host register interface. Each frame offered on the push port is stored in a circular buffer of up to 255 entries. The host always sees the oldest stored frame through a fixed read window. It releases frames from the head by writing a release count.

The host is not interrupted for every frame. A receive flag rises once the stored count is above a programmable threshold. An idle flag rises once the queue has held data for a programmable number of 100 µs periods with no host access to the window or to the release register. The 100 µs period comes from a prescaler sized from the system clock frequency parameter. A frame that arrives while the queue is full is dropped and raises an overrun flag. Each flag has an enable bit. The interrupt line is asserted while any enabled flag is set.

Top module: `rxq_coalesce`

## Requirements
- R1: After reset the count is 0, all flags and enables are 0, `irq` is low, the level register reads 5 and the timeout register reads 1000.
- R2: Frames leave in arrival order. Address 5 (window) returns the oldest stored frame, and it returns 0 when the queue is empty. Each accepted push raises the count, which reads in status bits [7:0] at address 3, by one.
- R3: Writing N to address 4 (release) removes min(N, count) frames from the head.
- R4: The receive flag (status bit 16) is set while the count is strictly greater than the level at address 1, bits [15:0]. With level 0 one frame sets it, with level 254 it takes 255 frames, and with level 5 five frames leave it clear.
- R5: A push while 255 frames are stored is discarded: the count stays at 255, the head frame is unchanged, and the overrun flag (status bit 17) is set.
- R6: The idle flag (status bit 23) is set once the queue has been non-empty and unaccessed for T ticks, where T is the value at address 2 and one tick is CLK_HZ/10000 clock cycles.
- R7: A window read (host_rd at address 5) or a release write restarts the idle time. An empty queue holds the idle time at zero.
- R8: Writing 1 to status bit 16, 17 or 23 clears that flag, and writing 0 leaves it unchanged. A flag whose set condition still holds stays set.
- R9: `irq` is the OR of each flag ANDed with its enable at address 0. The enables are bit 0 for receive, bit 1 for overrun and bit 7 for idle.
- R10: A push and a release in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_push | input | 1 | Offer one received frame |
| rx_data | input | DATA_W | Frame payload to store |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (counts as an access at the window) |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for host_addr (combinational) |
| irq | output | 1 | Coalesced interrupt |

## Verification
Short bursts checked against the default level show that the receive flag follows a strict "greater than" compare: five frames leave it clear and a sixth sets it. Level 0 and level 254 cover the two ends of that compare. The level-254 run fills the whole buffer, with the pointers already offset, and then pushes one more frame. This separates overrun and dropping from wrap-around order. Idle-time runs sample just before and just after the expected expiry cycle, both after a fresh push and after a window read. These runs show that the prescaler, the restart on access and the hold while empty each work. Mixed cases then check the release clamp, a push and a release in the same cycle, and write-one-to-clear while the set condition persists.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam logic [2:0] ADDR_IEN    = 3'd0;
   localparam logic [2:0] ADDR_LEVEL  = 3'd1;
   localparam logic [2:0] ADDR_TOUT   = 3'd2;
   localparam logic [2:0] ADDR_STATUS = 3'd3;
   localparam logic [2:0] ADDR_ACK    = 3'd4;
   localparam logic [2:0] ADDR_WINDOW = 3'd5;

   localparam int NUM_FLAGS = 3;
   localparam int FLG_RX    = 0;
   localparam int FLG_OVR   = 1;
   localparam int FLG_IDLE  = 2;

   // status bit of each flag
   function automatic int stat_bit(input int idx);
      case (idx)
         0:       return 16;
         1:       return 17;
         default: return 23;
      endcase
   endfunction

   // enable bit of each flag
   function automatic int en_bit(input int idx);
      case (idx)
         0:       return 0;
         1:       return 1;
         default: return 7;
      endcase
   endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DEPTH  = 255,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 8,
   parameter int REL_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              rel_req_i,
   input  logic [REL_W-1:0]  rel_n_i,
   output logic [DATA_W-1:0] head_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              drop_o
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   if (DEPTH < 2 || DEPTH > 255) begin : g_depth_bad
      $error("rxq_store: DEPTH must lie in 2..255");
   end
   if (CNT_W < $clog2(DEPTH + 1)) begin : g_cnt_bad
      $error("rxq_store: CNT_W too narrow for DEPTH");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  cnt_q, rel_amt;
   logic              full, push_ok;

   function automatic logic [PTR_W-1:0] ptr_add(input logic [PTR_W-1:0] p,
                                                input logic [CNT_W-1:0] n);
      int s;
      s = int'(p) + int'(n);
      if (s >= DEPTH) s = s - DEPTH;
      return PTR_W'(s);
   endfunction

   assign full    = (cnt_q == CNT_FULL);
   assign push_ok = push_i && !full;
   assign drop_o  = push_i && full;
   assign head_o  = mem[rd_ptr];
   assign cnt_o   = cnt_q;

   always_comb begin
      rel_amt = '0;
      if (rel_req_i) begin
         if (int'(rel_n_i) > int'(cnt_q)) rel_amt = cnt_q;
         else                             rel_amt = CNT_W'(rel_n_i);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (push_ok) wr_ptr <= ptr_add(wr_ptr, CNT_W'(1));
         rd_ptr <= ptr_add(rd_ptr, rel_amt);
         cnt_q  <= cnt_q + {{(CNT_W-1){1'b0}}, push_ok} - rel_amt;
      end
   end

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_FULL);

   // R5
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full && !rel_req_i) |=> (cnt_q == CNT_FULL && $stable(rd_ptr)));

   // R3
   release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_req_i && rel_n_i != '0 && cnt_q != '0 && !push_i) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
   parameter int TICK_DIV = 10000,
   parameter int TW       = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold_i,
   input  logic [TW-1:0] limit_i,
   output logic          expired_o
);
   localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
   localparam logic [TW-1:0]    IDLE_MAX = '1;

   if (TICK_DIV < 2) begin : g_div_bad
      $error("rxq_idle_timer: TICK_DIV must be at least 2");
   end

   logic [PRE_W-1:0] pre_q;
   logic [TW-1:0]    idle_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         idle_q <= '0;
      end else if (hold_i) begin
         pre_q  <= '0;
         idle_q <= '0;
      end else if (pre_q == PRE_LAST) begin
         pre_q <= '0;
         if (idle_q != IDLE_MAX) idle_q <= idle_q + TW'(1);
      end else begin
         pre_q <= pre_q + PRE_W'(1);
      end
   end

   assign expired_o = !hold_i && (idle_q >= limit_i);

   // R7
   idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> (idle_q == '0 && pre_q == '0));
endmodule

// File: rtl/rxq_flag.sv
module rxq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
endmodule

// File: rtl/rxq_coalesce.sv
module rxq_coalesce
   import rxq_pkg::*;
#(
   parameter int DEPTH           = 255,
   parameter int DATA_W          = 32,
   parameter int CLK_HZ          = 100_000_000,
   parameter int LEVEL_RST       = 5,
   parameter int TOUT_RST        = 1000,
   parameter bit MASK_EMPTY_READ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [2:0]        host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic              irq
);
   localparam int CNT_W    = $clog2(DEPTH + 1);
   localparam int LVL_W    = 16;
   localparam int TICK_DIV = CLK_HZ / 10000;

   if (DATA_W > 32 || DATA_W < 1) begin : g_width_bad
      $error("rxq_coalesce: DATA_W must lie in 1..32");
   end
   if (LEVEL_RST > 254 || LEVEL_RST < 0) begin : g_level_bad
      $error("rxq_coalesce: LEVEL_RST out of range");
   end

   logic [NUM_FLAGS-1:0] ien_q, flags, flag_set;
   logic [LVL_W-1:0]     level_q, tout_q;
   logic [CNT_W-1:0]     cnt;
   logic [DATA_W-1:0]    head, window;
   logic                 drop, expired, rel_req, access, sts_wr, empty;

   assign rel_req = host_wr && (host_addr == ADDR_ACK);
   assign sts_wr  = host_wr && (host_addr == ADDR_STATUS);
   assign access  = rel_req || (host_rd && (host_addr == ADDR_WINDOW));
   assign empty   = (cnt == '0);

   rxq_store #(
      .DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W), .REL_W(LVL_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .push_i(rx_push), .data_i(rx_data),
      .rel_req_i(rel_req), .rel_n_i(host_wdata[LVL_W-1:0]),
      .head_o(head), .cnt_o(cnt), .drop_o(drop)
   );

   rxq_idle_timer #(.TICK_DIV(TICK_DIV), .TW(LVL_W)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .hold_i(empty || access), .limit_i(tout_q),
      .expired_o(expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q   <= '0;
         level_q <= LVL_W'(LEVEL_RST);
         tout_q  <= LVL_W'(TOUT_RST);
      end else if (host_wr) begin
         case (host_addr)
            ADDR_IEN:
               for (int i = 0; i < NUM_FLAGS; i++) ien_q[i] <= host_wdata[en_bit(i)];
            ADDR_LEVEL: level_q <= host_wdata[LVL_W-1:0];
            ADDR_TOUT:  tout_q  <= host_wdata[LVL_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      flag_set           = '0;
      flag_set[FLG_RX]   = {{(LVL_W-CNT_W){1'b0}}, cnt} > level_q;
      flag_set[FLG_OVR]  = drop;
      flag_set[FLG_IDLE] = expired;
   end

   for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
      rxq_flag u_flag (
         .clk(clk), .rst_n(rst_n),
         .set_i(flag_set[gi]),
         .clr_i(sts_wr && host_wdata[stat_bit(gi)]),
         .q_o(flags[gi])
      );
   end

   if (MASK_EMPTY_READ) begin : g_mask_read
      assign window = empty ? '0 : head;
   end else begin : g_raw_read
      assign window = head;
   end

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         ADDR_IEN:
            for (int i = 0; i < NUM_FLAGS; i++) host_rdata[en_bit(i)] = ien_q[i];
         ADDR_LEVEL:  host_rdata[LVL_W-1:0] = level_q;
         ADDR_TOUT:   host_rdata[LVL_W-1:0] = tout_q;
         ADDR_STATUS: begin
            host_rdata[CNT_W-1:0] = cnt;
            for (int i = 0; i < NUM_FLAGS; i++) host_rdata[stat_bit(i)] = flags[i];
         end
         ADDR_WINDOW: host_rdata[DATA_W-1:0] = window;
         default: ;
      endcase
   end

   assign irq = |(flags & ien_q);

   // R4
   rx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({{(LVL_W-CNT_W){1'b0}}, cnt} > level_q) |=> flags[FLG_RX]);

   // R5
   overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && cnt == CNT_W'(DEPTH)) |=> flags[FLG_OVR]);

   // R9
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> !irq);
endmodule

// File: tb/rxq_coalesce_test.sv
module rxq_coalesce_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 255;
   localparam int CLK_HZ     = 40000;
   localparam int DIV        = CLK_HZ / 10000;

   localparam logic [2:0] A_IEN = 3'd0, A_LVL = 3'd1, A_TOUT = 3'd2,
                          A_STS = 3'd3, A_ACK = 3'd4, A_WIN = 3'd5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_push = 1'b0;
   logic [31:0] rx_data = '0;
   logic [2:0]  host_addr = A_STS;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        irq;

   int n_checks = 0;
   int n_err    = 0;
   logic [31:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   rxq_coalesce #(.DEPTH(DEPTH), .DATA_W(32), .CLK_HZ(CLK_HZ)) uut (
      .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_data(rx_data),
      .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
   );

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic peek(input logic [2:0] a, output logic [31:0] v);
      host_addr = a;
      #1;
      v = host_rdata;
      host_addr = A_STS;
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; host_addr = A_STS;
   endtask

   // driver: offers a frame and records what the queue must hold
   task automatic push(input logic [31:0] d);
      rx_push = 1'b1; rx_data = d;
      if (exp_q.size() < DEPTH) exp_q.push_back(d);
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   // monitor: window must show the scoreboard head, then release it
   task automatic pop_check(input string tag);
      logic [31:0] v;
      peek(A_WIN, v);
      check(tag, v, exp_q[0]);
      host_addr = A_WIN; host_rd = 1'b1;
      #1;
      @(negedge clk);
      host_rd = 1'b0;
      wr(A_ACK, 32'd1);
      void'(exp_q.pop_front());
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v;
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      peek(A_STS, v);  check("R1 status", v, 32'h0);
      peek(A_LVL, v);  check("R1 level", v, 32'd5);
      peek(A_TOUT, v); check("R1 timeout", v, 32'd1000);
      peek(A_IEN, v);  check("R1 enables", v, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);

      // R4 default level 5: five frames do not set the flag, six do
      for (int i = 0; i < 5; i++) push(32'hA000_0000 + i);
      step(1);
      peek(A_STS, v); check("R4 five frames", v, 32'h0000_0005);
      push(32'hA000_0005);
      step(1);
      peek(A_STS, v); check("R4 six frames", v, 32'h0001_0006);
      wr(A_IEN, 32'h1);
      check("R9 rx enable irq", {31'b0, irq}, 32'h1);

      // R2 order, R3 single releases
      for (int i = 0; i < 6; i++) pop_check("R2 order");
      peek(A_STS, v); check("R3 drained", v & 32'hFF, 32'h0);

      // R8 clear, R9 irq falls
      wr(A_STS, 32'h0001_0000);
      peek(A_STS, v); check("R8 rx cleared", v, 32'h0);
      check("R9 irq low", {31'b0, irq}, 32'h0);

      // R4 level 0, R8 persistence
      wr(A_LVL, 32'd0);
      push(32'hB000_0001);
      step(1);
      peek(A_STS, v); check("R4 level0 one frame", v, 32'h0001_0001);
      wr(A_STS, 32'h0001_0000);
      peek(A_STS, v); check("R8 condition holds", v, 32'h0001_0001);
      pop_check("R2 single");
      wr(A_STS, 32'h0001_0000);
      peek(A_STS, v); check("R8 cleared empty", v, 32'h0);

      // R3 multi release and clamp
      for (int i = 0; i < 4; i++) push(32'hC000_0001 + i);
      wr(A_ACK, 32'd3);
      for (int i = 0; i < 3; i++) void'(exp_q.pop_front());
      peek(A_STS, v); check("R3 release 3", v & 32'hFF, 32'd1);
      peek(A_WIN, v); check("R3 head after release", v, exp_q[0]);
      wr(A_ACK, 32'd10);
      exp_q.delete();
      peek(A_STS, v); check("R3 clamp", v & 32'hFF, 32'd0);
      peek(A_WIN, v); check("R2 empty window", v, 32'h0);

      // R10 push and release together
      push(32'hD000_0001);
      push(32'hD000_0002);
      rx_push = 1'b1; rx_data = 32'hD000_0003;
      host_addr = A_ACK; host_wdata = 32'd1; host_wr = 1'b1;
      @(negedge clk);
      rx_push = 1'b0; host_wr = 1'b0; host_addr = A_STS;
      void'(exp_q.pop_front()); exp_q.push_back(32'hD000_0003);
      peek(A_STS, v); check("R10 count", v & 32'hFF, 32'd2);
      pop_check("R10 head");
      pop_check("R10 tail");

      // R4 level 254 and R5 overrun on a wrapped buffer
      wr(A_LVL, 32'd254);
      wr(A_IEN, 32'h0);
      wr(A_STS, 32'h0083_0000);
      for (int i = 0; i < 254; i++) push(32'h0000_1000 + i);
      step(1);
      peek(A_STS, v); check("R4 254 frames", v, 32'h0000_00FE);
      push(32'h0000_10FE);
      step(1);
      peek(A_STS, v); check("R4 255 frames", v, 32'h0001_00FF);
      push(32'hDEAD_BEEF);
      peek(A_STS, v); check("R5 overrun full", v, 32'h0003_00FF);
      peek(A_WIN, v); check("R5 head kept", v, 32'h0000_1000);
      check("R9 disabled irq", {31'b0, irq}, 32'h0);
      wr(A_IEN, 32'h2);
      check("R9 overrun irq", {31'b0, irq}, 32'h1);
      wr(A_STS, 32'h0);
      peek(A_STS, v); check("R8 zero write", v, 32'h0003_00FF);
      wr(A_STS, 32'h0002_0000);
      peek(A_STS, v); check("R8 overrun cleared", v, 32'h0001_00FF);
      check("R9 irq after clear", {31'b0, irq}, 32'h0);
      for (int i = 0; i < 3; i++) pop_check("R2 wrapped order");
      wr(A_ACK, 32'd255);
      exp_q.delete();
      wr(A_STS, 32'h0083_0000);
      peek(A_STS, v); check("R3 full release", v, 32'h0);

      // R6 idle timeout of 3 ticks
      wr(A_TOUT, 32'd3);
      wr(A_IEN, 32'h80);
      push(32'hE000_0001);
      step(3 * DIV - 1);
      peek(A_STS, v); check("R6 before expiry", v, 32'h0000_0001);
      step(3);
      peek(A_STS, v); check("R6 after expiry", v, 32'h0080_0001);
      check("R9 idle irq", {31'b0, irq}, 32'h1);

      // R7 window read restarts the idle time
      host_addr = A_WIN; host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0; host_addr = A_STS;
      wr(A_STS, 32'h0080_0000);
      step(3 * DIV - 2);
      peek(A_STS, v); check("R7 restarted", v, 32'h0000_0001);
      step(3);
      peek(A_STS, v); check("R7 expiry again", v, 32'h0080_0001);

      // R7 empty queue holds the timer
      wr(A_ACK, 32'd1);
      void'(exp_q.pop_front());
      wr(A_STS, 32'h0080_0000);
      step(8 * DIV);
      peek(A_STS, v); check("R7 empty hold", v, 32'h0);
      check("R9 final irq", {31'b0, irq}, 32'h0);

      summary();
      $finish;
   end
endmodule